// File: doc/BRIEF.md
# Parallel Configuration Host Sequencer

This block is the host side of a byte-wide passive loading link for a chain of programmable devices. The devices share one reset line, one byte clock, one data bus, one open-drain status line and one open-drain completion line. The sequencer reads configuration bytes from a synchronous memory port and sends the whole image as one stream. It does not know where one device's share ends and the next one begins. It raises a one-cycle `done_o` pulse when the shared completion line goes high. It raises a one-cycle `error_o` pulse when loading cannot finish.

A `start_i` pulse begins the sequence. The host holds the chain reset low for a timed pulse, waits for the status line to be released, then clocks out bytes from address 0 up to `LAST_ADDR`. Each byte takes one two-cycle period of the byte clock. If the devices have not signalled completion when the image ends, the byte clock keeps running for a fixed number of extra periods. If any device pulls the status line low, streaming stops at once. Recovery then takes one of two forms. In automatic mode the host waits for the line to come back high. In forced mode it issues a fresh reset pulse. In both modes the stream restarts from address 0.

The lines from the chain are treated as synchronous to `clk`. The pulse length and the watchdog limit are derived from `CLK_KHZ`.

Top module: `pcfg_host_seq`

## Requirements
- R1: Out of reset: `chain_reset_n_o` is high, `chain_clk_o` is low, and `mem_rd_o`, `busy_o`, `done_o` and `error_o` are all low.
- R2: After `start_i` in idle, `chain_reset_n_o` is low for at least PULSE_CYC = ceil(CLK_KHZ*PULSE_US/1000) cycles. No byte-clock edge occurs until `chain_ok_i` is high after the reset is released.
- R3: Bytes reach the chain in address order 0..LAST_ADDR, one byte per rising edge of `chain_clk_o`. `chain_data_o` changes only on a clock edge that leaves `chain_clk_o` low.
- R4: While streaming and in the tail, `chain_clk_o` has a period of two cycles (one low, one high). A fault-free load issues exactly LAST_ADDR+1 memory reads, and two reads are never back to back.
- R5: `chain_done_i` high while streaming or in the tail gives one `done_o` pulse of a single cycle. `busy_o` falls with it, and the byte clock stops.
- R6: After the last byte, exactly TAIL_CLKS further rising edges occur with the data held at the last byte. If `chain_done_i` is still low after them, one `error_o` pulse follows.
- R7: With `auto_restart_i`=1, `chain_ok_i` low during streaming or the tail stops the byte clock and leaves `chain_reset_n_o` high. Streaming restarts from address 0 once `chain_ok_i` returns high.
- R8: With `auto_restart_i`=0, the same fault causes a new reset pulse of at least PULSE_CYC cycles, and streaming then restarts from address 0.
- R9: If `chain_ok_i` is still low WDOG_CYC = ceil(CLK_KHZ*WDOG_US/1000) cycles after a release wait begins, `error_o` pulses and the block returns to idle.
- R10: `start_i` while busy has no effect: one reset pulse only, and the byte order is unchanged.
- R11: `busy_o` is high from the cycle after `start_i` until the cycle in which `done_o` or `error_o` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load (idle only) |
| auto_restart_i | input | 1 | 1: wait for status release after a fault; 0: re-pulse the chain reset |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rd_o | output | 1 | Memory read strobe; data appears on the next cycle |
| mem_data_i | input | 8 | Memory read data |
| chain_reset_n_o | output | 1 | Shared active-low chain reset |
| chain_clk_o | output | 1 | Shared byte clock |
| chain_data_o | output | 8 | Shared byte bus |
| chain_ok_i | input | 1 | Shared status line, low while any device is in reset or fault |
| chain_done_i | input | 1 | Shared completion line |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle failure pulse (timeout or watchdog) |

## Verification
The hardest case to reach is a status fault that lands on one exact byte of the chain. The fault at the final byte matters most, because by then the host has left streaming and entered the tail. The bench models the chain: it pulls the status line low on a chosen rising-edge count, then releases it. It sweeps that count across every byte position in both recovery modes. In each case it checks that the captured stream is the prefix sent before the fault, followed by the full image again from address 0.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_RELWAIT,
        ST_LOAD,
        ST_STREAM,
        ST_TAIL,
        ST_HOLD
    } pcfg_state_e;

    // Cycles needed to cover a time in microseconds, rounded up.
    function automatic int us_to_cycles(input int clk_khz, input int us);
        return (clk_khz * us + 999) / 1000;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pcfg_ctrl.sv
module pcfg_ctrl
    import pcfg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LAST_ADDR = 255,
    parameter int TMR_W     = 16,
    parameter int PULSE_CYC = 200,
    parameter int WDOG_CYC  = 50000,
    parameter int TAIL_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              auto_restart_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [7:0]        mem_data_i,
    output logic              chain_reset_n_o,
    output logic              chain_clk_o,
    output logic [7:0]        chain_data_o,
    input  logic              chain_ok_i,
    input  logic              chain_done_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o,
    output logic              tmr_load_o,
    output logic [TMR_W-1:0]  tmr_val_o,
    input  logic              tmr_zero_i
);

    localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(LAST_ADDR);
    localparam logic [TMR_W-1:0]  PULSE_T = TMR_W'(PULSE_CYC);
    localparam logic [TMR_W-1:0]  WDOG_T  = TMR_W'(WDOG_CYC);
    localparam logic [TMR_W-1:0]  TAIL_T  = TMR_W'(2 * TAIL_CLKS);

    typedef struct packed {
        pcfg_state_e       st;
        logic              ph;
        logic              last;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              dclk;
        logic              rstn;
        logic              done;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.err    = 1'b0;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st     = ST_PULSE;
                    r_d.rstn   = 1'b0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = PULSE_T;
                end
            end
            ST_PULSE: begin
                if (tmr_zero_i) begin
                    r_d.rstn   = 1'b1;
                    r_d.st     = ST_RELWAIT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = WDOG_T;
                end
            end
            ST_RELWAIT, ST_HOLD: begin
                if (chain_ok_i) begin
                    r_d.st   = ST_LOAD;
                    r_d.addr = '0;
                    r_d.last = 1'b0;
                    r_d.ph   = 1'b0;
                end else if (tmr_zero_i) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end
            end
            ST_LOAD: begin
                r_d.st = ST_STREAM;
            end
            ST_STREAM, ST_TAIL: begin
                if (!chain_ok_i) begin
                    r_d.dclk   = 1'b0;
                    tmr_load_o = 1'b1;
                    if (auto_restart_i) begin
                        r_d.st    = ST_HOLD;
                        tmr_val_o = WDOG_T;
                    end else begin
                        r_d.st    = ST_PULSE;
                        r_d.rstn  = 1'b0;
                        tmr_val_o = PULSE_T;
                    end
                end else if (chain_done_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.dclk = 1'b0;
                end else if (r_q.st == ST_STREAM) begin
                    if (!r_q.ph) begin
                        // falling edge: present the byte fetched last cycle
                        r_d.dclk = 1'b0;
                        r_d.data = mem_data_i;
                        r_d.ph   = 1'b1;
                        if (r_q.addr == LAST_A) begin
                            r_d.last = 1'b1;
                        end else begin
                            r_d.addr = r_q.addr + 1'b1;
                        end
                    end else begin
                        r_d.dclk = 1'b1;
                        r_d.ph   = 1'b0;
                        if (r_q.last) begin
                            r_d.st     = ST_TAIL;
                            tmr_load_o = 1'b1;
                            tmr_val_o  = TAIL_T;
                        end
                    end
                end else begin
                    if (tmr_zero_i) begin
                        r_d.st   = ST_IDLE;
                        r_d.err  = 1'b1;
                        r_d.dclk = 1'b0;
                    end else begin
                        r_d.dclk = ~r_q.dclk;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ph: 1'b0, last: 1'b0, addr: '0, data: '0,
                     dclk: 1'b0, rstn: 1'b1, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr_o      = r_q.addr;
    assign mem_rd_o        = (r_q.st == ST_LOAD) ||
                             ((r_q.st == ST_STREAM) && r_q.ph && !r_q.last);
    assign chain_reset_n_o = r_q.rstn;
    assign chain_clk_o     = r_q.dclk;
    assign chain_data_o    = r_q.data;
    assign busy_o          = (r_q.st != ST_IDLE);
    assign done_o          = r_q.done;
    assign error_o         = r_q.err;

    // R2: no clocking or reads while the chain is held in reset
    a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.rstn |-> (!r_q.dclk && !mem_rd_o));

    // R3: data moves only on an edge that leaves the clock low
    a_r3_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.data) |-> !r_q.dclk);

    // R4: reads are spaced at least two cycles apart
    a_r4_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o);

    // R5: completion pulse lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    // R7: automatic recovery never touches the chain reset
    a_r7_hold_keeps_reset_high: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD) |-> r_q.rstn);

    // R8: every stream begins at address zero
    a_r8_load_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOAD) |-> (r_q.addr == '0 && !r_q.last));

    // R10: start while streaming leaves the transfer running
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_STREAM) && start_i && chain_ok_i && !chain_done_i)
        |=> (r_q.st == ST_STREAM || r_q.st == ST_TAIL));

    // R11: result pulses coincide with the return to idle
    a_r11_idle_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done || r_q.err) |-> (!busy_o && !(r_q.done && r_q.err)));

endmodule

// File: rtl/pcfg_host_seq.sv
module pcfg_host_seq
    import pcfg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LAST_ADDR = 255,
    parameter int CLK_KHZ   = 100000,
    parameter int PULSE_US  = 2,
    parameter int WDOG_US   = 500,
    parameter int TAIL_CLKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              auto_restart_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [7:0]        mem_data_i,
    output logic              chain_reset_n_o,
    output logic              chain_clk_o,
    output logic [7:0]        chain_data_o,
    input  logic              chain_ok_i,
    input  logic              chain_done_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o
);

    localparam int PULSE_CYC = us_to_cycles(CLK_KHZ, PULSE_US);
    localparam int WDOG_CYC  = us_to_cycles(CLK_KHZ, WDOG_US);
    localparam int TMR_MAX   = imax(imax(PULSE_CYC, WDOG_CYC), 2 * TAIL_CLKS);
    localparam int TMR_W     = $clog2(TMR_MAX + 1);

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;

    pcfg_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    pcfg_ctrl #(
        .ADDR_W    (ADDR_W),
        .LAST_ADDR (LAST_ADDR),
        .TMR_W     (TMR_W),
        .PULSE_CYC (PULSE_CYC),
        .WDOG_CYC  (WDOG_CYC),
        .TAIL_CLKS (TAIL_CLKS)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .auto_restart_i  (auto_restart_i),
        .mem_addr_o      (mem_addr_o),
        .mem_rd_o        (mem_rd_o),
        .mem_data_i      (mem_data_i),
        .chain_reset_n_o (chain_reset_n_o),
        .chain_clk_o     (chain_clk_o),
        .chain_data_o    (chain_data_o),
        .chain_ok_i      (chain_ok_i),
        .chain_done_i    (chain_done_i),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .error_o         (error_o),
        .tmr_load_o      (tmr_load),
        .tmr_val_o       (tmr_val),
        .tmr_zero_i      (tmr_zero)
    );

endmodule

// File: tb/pcfg_host_seq_tb.sv
module pcfg_host_seq_tb;

    localparam int CLK_NS = 10;
    localparam int AW     = 3;
    localparam int LAST   = 5;
    localparam int NB     = LAST + 1;
    localparam int KHZ    = 1000;
    localparam int PCYC   = 2;    // ceil(1000*2/1000)
    localparam int WCYC   = 500;  // ceil(1000*500/1000)
    localparam int TCLK   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          auto_r = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic [7:0]    mem_q = '0;
    logic          rstn_o, dclk, busy, done, err;
    logic [7:0]    data;
    logic          nst = 1'b1;
    logic          cd = 1'b0;

    pcfg_host_seq #(
        .ADDR_W(AW), .LAST_ADDR(LAST), .CLK_KHZ(KHZ),
        .PULSE_US(2), .WDOG_US(500), .TAIL_CLKS(TCLK)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .auto_restart_i(auto_r),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_data_i(mem_q),
        .chain_reset_n_o(rstn_o), .chain_clk_o(dclk), .chain_data_o(data),
        .chain_ok_i(nst), .chain_done_i(cd),
        .busy_o(busy), .done_o(done), .error_o(err)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int vec = 0;
    int bad = 0;
    int cyc = 0;
    int seed = 0;
    bit finished = 0;

    // chain model controls and observations
    int rel_dly = 3, fault_at = 0, fault_len = 0, cd_after = -1;
    bit fault_armed = 0;
    int rel_cnt = 0, rises = 0, cap_n = 0, pulses = 0, lowlen = 0, minlow = 0;
    int reads = 0, bad_sp = 0, bad_dat = 0, last_rise = -1, fault_cyc = -1;
    logic [7:0] cap [0:255];
    logic dclk_prev = 1'b0, rst_prev = 1'b1;
    logic [7:0] data_prev = '0;

    function automatic logic [7:0] fmem(input int a);
        return 8'(a * 37 + 11 + seed * 5);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd) mem_q <= fmem(int'(mem_addr));
    end

    always @(negedge clk) if (rst_n) begin
        if (!rstn_o) begin
            if (rst_prev) pulses++;
            lowlen++;
            nst = 1'b0; rel_cnt = rel_dly; rises = 0; cd = 1'b0; last_rise = -1;
        end else begin
            if (!rst_prev) begin
                if (lowlen < minlow) minlow = lowlen;
                lowlen = 0;
            end
            if (!nst) begin
                if (rel_cnt <= 0) nst = 1'b1; else rel_cnt--;
            end else if (dclk && !dclk_prev) begin
                cap[cap_n % 256] = data; cap_n++; rises++;
                if (last_rise >= 0 && cyc - last_rise != 2) bad_sp++;
                last_rise = cyc;
                if (fault_armed && rises == fault_at) begin
                    nst = 1'b0; rel_cnt = fault_len; fault_armed = 0;
                    rises = 0; fault_cyc = cyc; last_rise = -1;
                end else if (cd_after >= 0 && rises >= cd_after) begin
                    cd = 1'b1;
                end
            end
        end
        if (mem_rd) reads++;
        if (dclk && data != data_prev) bad_dat++;
        rst_prev = rstn_o; dclk_prev = dclk; data_prev = data;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    bit got_done, got_err;
    int end_cyc;

    task automatic do_run(input bit am, input int fat, input int flen,
                          input int cda, input int rdly, input int xstart);
        int n;
        seed++;
        auto_r = am; fault_at = fat; fault_armed = (fat > 0); fault_len = flen;
        cd_after = cda; rel_dly = rdly;
        cap_n = 0; pulses = 0; minlow = 1 << 30; reads = 0; bad_sp = 0;
        bad_dat = 0; fault_cyc = -1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
        n = 1;
        while (!(done || err) && n < 5000) begin
            @(negedge clk);
            n++;
            start = (n == xstart);
        end
        start = 1'b0;
        got_done = done; got_err = err; end_cyc = cyc;
        chk(busy == 1'b0, "R11 busy low at result", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0 && err == 1'b0, "R5 single-cycle result pulse",
            int'(done) + int'(err), 0);
        chk(bad_dat == 0, "R3 data changed while clock high", bad_dat, 0);
        chk(bad_sp == 0, "R4 clock period not two cycles", bad_sp, 0);
    endtask

    task automatic chk_image(input int base, input string req);
        for (int i = 0; i < NB; i++)
            chk(cap[(base + i) % 256] == fmem(i), req,
                int'(cap[(base + i) % 256]), int'(fmem(i)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rstn_o == 1'b1, "R1 chain reset high", int'(rstn_o), 1);
        chk(dclk == 1'b0 && mem_rd == 1'b0, "R1 clock and read idle",
            int'(dclk) + int'(mem_rd), 0);
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 status idle",
            int'(busy) + int'(done) + int'(err), 0);

        // Clean loads with completion k rises after the image (R3 R4 R5 R6)
        for (int k = 0; k <= TCLK; k++) begin
            do_run(1'b0, 0, 0, NB + k, 3, 0);
            chk(got_done && !got_err, "R5 completion reported", int'(got_done), 1);
            chk(cap_n == NB + k, "R6 extra rising edges before completion", cap_n, NB + k);
            chk_image(0, "R3 byte order");
            chk(reads == NB, "R4 one read per byte", reads, NB);
            chk(pulses == 1, "R2 single reset pulse", pulses, 1);
            chk(minlow >= PCYC, "R2 reset pulse length", minlow, PCYC);
            for (int i = NB; i < cap_n; i++)
                chk(cap[i] == fmem(LAST), "R6 data held in tail", int'(cap[i]), int'(fmem(LAST)));
        end

        // No completion: tail timeout (R6)
        do_run(1'b1, 0, 0, -1, 3, 0);
        chk(got_err && !got_done, "R6 timeout error", int'(got_err), 1);
        chk(cap_n == NB + TCLK, "R6 tail edge count", cap_n, NB + TCLK);

        // Fault at every byte position, both modes (R7 R8)
        for (int am = 0; am < 2; am++) begin
            for (int f = 1; f <= NB; f++) begin
                do_run(am[0], f, 4, NB, 3, 0);
                chk(got_done, am ? "R7 auto recovery completes" : "R8 forced recovery completes",
                    int'(got_done), 1);
                chk(cap_n == f + NB, am ? "R7 stream length" : "R8 stream length", cap_n, f + NB);
                for (int i = 0; i < f; i++)
                    chk(cap[i] == fmem(i), "R3 prefix before fault", int'(cap[i]), int'(fmem(i)));
                chk_image(f, am ? "R7 restart from address 0" : "R8 restart from address 0");
                chk(pulses == (am ? 1 : 2), am ? "R7 no reset pulse" : "R8 reset re-pulsed",
                    pulses, am ? 1 : 2);
                chk(minlow >= PCYC, "R8 pulse length", minlow, PCYC);
            end
        end

        // Status never released in auto mode: watchdog (R9)
        do_run(1'b1, 2, 100000, -1, 3, 0);
        chk(got_err && !got_done, "R9 hold watchdog error", int'(got_err), 1);
        chk((end_cyc - fault_cyc) >= WCYC && (end_cyc - fault_cyc) <= WCYC + 4,
            "R9 hold watchdog timing", end_cyc - fault_cyc, WCYC + 2);
        chk(pulses == 1 && rstn_o == 1'b1, "R7 reset untouched during watchdog", pulses, 1);

        // Status never released after reset pulse (R9)
        do_run(1'b0, 0, 0, NB, 100000, 0);
        chk(got_err && !got_done, "R9 release watchdog error", int'(got_err), 1);
        chk(cap_n == 0, "R2 no clock before release", cap_n, 0);

        // Start while busy (R10)
        do_run(1'b0, 0, 0, NB, 3, 14);
        chk(got_done, "R10 load completes", int'(got_done), 1);
        chk(pulses == 1, "R10 no extra reset pulse", pulses, 1);
        chk_image(0, "R10 byte order kept");

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            finished = 1;
            vec++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

endmodule